// File: doc/BRIEF.md
# Shared SRAM Bus Loader

This block lets an on-chip agent load and inspect an external 128K x 8 asynchronous SRAM that normally belongs to a host system. The block has two modes. In run mode it turns off every pad driver for the address, data and strobe lines and lets the host's reset pin go high, so the host owns the memory. In program mode it pulls the host's reset pin low and drives the memory bus itself. In that mode it carries out single-byte writes and reads.

The internal side takes a mode level plus single-cycle write or read request pulses, each with a 17-bit byte address. Each access sends a done pulse when it ends. An access requested in run mode is refused: the block raises an error flag together with done and does nothing on the bus. The pad side presents each memory line as an output value plus a drive enable. The pad ring turns a cleared enable into high impedance. The low sixteen address bits come out as two byte-wide groups, and bit 16 has its own pin.

Top module: `sram_bus_loader`

## Requirements
- R1: After reset the block is in run mode. padSysRstN is 1, padAddrOe, padDataOe and padStrobeOe are 0, padWeN and padOeN are 1, and done and err are 0.
- R2: In run mode the address, data and strobe drive enables are 0 and padSysRstN is 1.
- R3: In program mode padSysRstN is 0, padAddrOe and padStrobeOe are 1, and padDataOe is 1 whenever no read is in progress.
- R4: A write drives the address and the request byte and pulls padWeN low for exactly STROBE_CYC consecutive cycles. The byte on padDataOut while padWeN is low equals the requested byte.
- R5: A read turns padDataOe off and pulls padOeN low for exactly STROBE_CYC cycles. padDataOe stays 0 for every cycle in which padOeN is low. rspData then holds the byte present on padDataIn during the last cycle of that low period.
- R6: From the start of a read, padDataOut is 0x00, and it remains 0x00 after the read until the next write.
- R7: A request made in run mode gives done=1 and err=1 for one cycle, in the cycle right after the request is sampled. padWeN and padOeN do not fall.
- R8: padWeN and padOeN are never 0 in the same cycle.
- R9: The address appears as padAddrLo = bits 7:0, padAddrHi = bits 15:8 and padAddrTop = bit 16. It is on the pins one cycle before a strobe falls, stays stable while the strobe is low, and is held for one cycle after the strobe rises.
- R10: A change of progMode takes effect only while no access is in progress. A change made during an access takes effect in the cycle after done.
- R11: done is a one-cycle pulse, high in the cycle STROBE_CYC+2 clock edges after the edge that samples the request. Requests that arrive while an access is in progress are ignored.
- R12: If wrReq and rdReq are both high in the same cycle, the block performs the write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progMode | input | 1 | 1 requests program mode, 0 requests run mode |
| wrReq | input | 1 | Single-cycle write request |
| rdReq | input | 1 | Single-cycle read request |
| reqAddr | input | 17 | Byte address of the request |
| reqData | input | 8 | Byte to write |
| rspData | output | 8 | Byte returned by the last read |
| done | output | 1 | One-cycle pulse that ends an access or a refusal |
| err | output | 1 | High with done when a request was refused in run mode |
| padAddrLo | output | 8 | Address bits 7:0 |
| padAddrHi | output | 8 | Address bits 15:8 |
| padAddrTop | output | 1 | Address bit 16 |
| padAddrOe | output | 1 | Drive enable for all address pins |
| padDataOut | output | 8 | Data bus output value |
| padDataOe | output | 1 | Data bus drive enable |
| padDataIn | input | 8 | Data bus value seen at the pads |
| padWeN | output | 1 | Active-low write strobe |
| padOeN | output | 1 | Active-low output-enable strobe |
| padStrobeOe | output | 1 | Drive enable for both strobe pins |
| padSysRstN | output | 1 | Active-low host reset, always driven |

## Verification
The bench targets the address extremes 0x00000, 0x0FFFF, 0x10000 and 0x1FFFF. A design that misplaced bit 16 would alias the two halves of the memory, and the read-back would return the wrong byte. It checks that the data output register reads zero during and after a read, which catches a design that leaves a stale written byte on the bus. It also checks the data driver during the output-enable window, which catches a design that fights the memory. A mode drop in the middle of an access must not release the host early. Requests that arrive during an access, or that are made together, must produce exactly one write and no read; a design that queued or merged them would show extra strobe edges or a second done.

// File: rtl/sram_loader_pkg.sv
package sram_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic loadAddr;
    logic loadWrData;
    logic clearData;
    logic captureRd;
  } dpCtl_t;
endpackage

// File: rtl/sram_loader_ctrl.sv
module sram_loader_ctrl
  import sram_loader_pkg::*;
#(
  parameter int STROBE_CYC = 5
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   progMode,
  input  logic   wrReq,
  input  logic   rdReq,
  output dpCtl_t dpCtl,
  output logic   progQ,
  output logic   weN,
  output logic   oeN,
  output logic   dataRelease,
  output logic   done,
  output logic   err
);
  localparam int CNT_W = $clog2(STROBE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYC - 1);

  seqState_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic isRdQ;
  logic anyReq;
  logic accept;

  assign anyReq = wrReq || rdReq;
  assign accept = (stateQ == ST_IDLE) && anyReq && progQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      isRdQ  <= 1'b0;
      progQ  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            stateQ <= ST_SETUP;
            isRdQ  <= !wrReq;
          end else begin
            if (anyReq) begin
              done <= 1'b1;
              err  <= 1'b1;
            end
            progQ <= progMode;
          end
        end
        ST_SETUP: begin
          stateQ <= ST_STROBE;
          cntQ   <= '0;
        end
        ST_STROBE: begin
          if (cntQ == LAST_CNT) stateQ <= ST_HOLD;
          else cntQ <= cntQ + 1'b1;
        end
        ST_HOLD: begin
          stateQ <= ST_IDLE;
          done   <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.loadAddr   = accept;
    dpCtl.loadWrData = accept && wrReq;
    dpCtl.clearData  = accept && !wrReq;
    dpCtl.captureRd  = (stateQ == ST_STROBE) && isRdQ && (cntQ == LAST_CNT);
  end

  assign weN         = !((stateQ == ST_STROBE) && !isRdQ);
  assign oeN         = !((stateQ == ST_STROBE) && isRdQ);
  assign dataRelease = isRdQ && (stateQ != ST_IDLE);
endmodule

// File: rtl/sram_loader_datapath.sv
module sram_loader_datapath
  import sram_loader_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] rspData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut <= '0;
      dataOut <= '0;
      rspData <= '0;
    end else begin
      if (dpCtl.loadAddr) addrOut <= reqAddr;
      if (dpCtl.loadWrData) dataOut <= reqData;
      else if (dpCtl.clearData) dataOut <= '0;
      if (dpCtl.captureRd) rspData <= busIn;
    end
  end
endmodule

// File: rtl/sram_bus_loader.sv
module sram_bus_loader
  import sram_loader_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int GROUP_W    = 8,
  parameter int STROBE_CYC = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         progMode,
  input  logic                         wrReq,
  input  logic                         rdReq,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W-1:0]            reqData,
  output logic [DATA_W-1:0]            rspData,
  output logic                         done,
  output logic                         err,
  output logic [GROUP_W-1:0]           padAddrLo,
  output logic [GROUP_W-1:0]           padAddrHi,
  output logic [ADDR_W-2*GROUP_W-1:0]  padAddrTop,
  output logic                         padAddrOe,
  output logic [DATA_W-1:0]            padDataOut,
  output logic                         padDataOe,
  input  logic [DATA_W-1:0]            padDataIn,
  output logic                         padWeN,
  output logic                         padOeN,
  output logic                         padStrobeOe,
  output logic                         padSysRstN
);
  localparam int LOW_W = 2 * GROUP_W;

  dpCtl_t dpCtl;
  logic progQ;
  logic dataRelease;
  logic [ADDR_W-1:0] addrQ;

  sram_loader_ctrl #(.STROBE_CYC(STROBE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .progMode(progMode), .wrReq(wrReq), .rdReq(rdReq),
    .dpCtl(dpCtl), .progQ(progQ), .weN(padWeN), .oeN(padOeN),
    .dataRelease(dataRelease), .done(done), .err(err)
  );

  sram_loader_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqAddr(reqAddr), .reqData(reqData),
    .busIn(padDataIn), .addrOut(addrQ), .dataOut(padDataOut), .rspData(rspData)
  );

  assign padAddrLo   = addrQ[GROUP_W-1:0];
  assign padAddrHi   = addrQ[LOW_W-1:GROUP_W];
  assign padAddrTop  = addrQ[ADDR_W-1:LOW_W];
  assign padAddrOe   = progQ;
  assign padStrobeOe = progQ;
  assign padDataOe   = progQ && !dataRelease;
  assign padSysRstN  = !progQ;
endmodule

// File: rtl/sram_loader_chk.sv
module sram_loader_chk #(
  parameter int ADDR_W     = 17,
  parameter int GROUP_W    = 8,
  parameter int STROBE_CYC = 5
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [GROUP_W-1:0]          padAddrLo,
  input logic [GROUP_W-1:0]          padAddrHi,
  input logic [ADDR_W-2*GROUP_W-1:0] padAddrTop,
  input logic                        padAddrOe,
  input logic                        padDataOe,
  input logic                        padStrobeOe,
  input logic                        padSysRstN,
  input logic                        padWeN,
  input logic                        padOeN,
  input logic                        done,
  input logic                        err
);
  logic [ADDR_W-1:0] fullAddr;
  logic strobeOn;
  logic [15:0] lowCnt;

  assign fullAddr = {padAddrTop, padAddrHi, padAddrLo};
  assign strobeOn = !padWeN || !padOeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (strobeOn) lowCnt <= lowCnt + 16'd1;
    else lowCnt <= '0;
  end

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    padWeN || padOeN);

  // R2
  run_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    padSysRstN |-> (!padAddrOe && !padDataOe && !padStrobeOe));

  // R3
  prog_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !padSysRstN |-> (padAddrOe && padStrobeOe));

  // R5
  read_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !padOeN |-> !padDataOe);

  // R9
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeOn |-> $stable(fullAddr));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeOn) |=> $stable(fullAddr));

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeOn && lowCnt != 16'd0) |-> (lowCnt == 16'(STROBE_CYC)));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind sram_bus_loader sram_loader_chk #(
  .ADDR_W(ADDR_W), .GROUP_W(GROUP_W), .STROBE_CYC(STROBE_CYC)
) u_chk (.*);

// File: tb/sram_bus_loader_bench.sv
module sram_bus_loader_bench;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progMode = 1'b0, wrReq = 1'b0, rdReq = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic [7:0] rspData, padAddrLo, padAddrHi, padDataOut;
  logic [7:0] padDataIn = 8'hA5;
  logic [0:0] padAddrTop;
  logic done, err, padAddrOe, padDataOe, padWeN, padOeN, padStrobeOe, padSysRstN;

  int checks = 0, errors = 0;
  int weFalls = 0, oeFalls = 0;
  logic [7:0] sramModel [int];
  logic [7:0] expMem [int];

  always #10 clk = ~clk;

  sram_bus_loader #(.STROBE_CYC(N)) u_sram_bus_loader (.*);

  wire [16:0] pinAddr = {padAddrTop, padAddrHi, padAddrLo};

  always @(negedge padWeN) weFalls++;
  always @(negedge padOeN) oeFalls++;
  always @(posedge padWeN) if (padStrobeOe && padDataOe) sramModel[int'(pinAddr)] = padDataOut;
  always @(negedge padOeN) padDataIn = sramModel.exists(int'(pinAddr)) ? sramModel[int'(pinAddr)] : 8'h00;
  always @(posedge padOeN) padDataIn = 8'hA5;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doAccess(input bit wr, input bit rd, input logic [16:0] a,
                          input logic [7:0] d, output logic [7:0] rsp);
    int cyc = 0, weLow = 0, oeLow = 0, both = 0;
    @(negedge clk);
    wrReq = wr; rdReq = rd; reqAddr = a; reqData = d;
    @(negedge clk);
    wrReq = 0; rdReq = 0; cyc = 1;
    while (!done && cyc < 40) begin
      if (!padWeN) begin
        weLow++;
        check(padDataOe && padDataOut == d, "R4 write data", padDataOut, d);
      end
      if (!padOeN) begin
        oeLow++;
        check(!padDataOe, "R5 bus released", padDataOe, 0);
        check(padDataOut == 8'h00, "R6 cleared", padDataOut, 0);
      end
      if (!padWeN && !padOeN) both++;
      if (!padWeN || !padOeN) check(pinAddr == a, "R9 address pins", pinAddr, a);
      @(negedge clk);
      cyc++;
    end
    check(cyc == N + 3, "R11 done latency", cyc, N + 3);
    check(!err, "R11 no error", err, 0);
    check(weLow == (wr ? N : 0), "R4 WE width", weLow, wr ? N : 0);
    check(oeLow == (wr ? 0 : N), "R5 OE width", oeLow, wr ? 0 : N);
    check(both == 0, "R8 exclusive", both, 0);
    rsp = rspData;
  endtask

  task automatic tReset();
    check(padSysRstN && !padAddrOe && !padDataOe && !padStrobeOe, "R1 pads released",
          {padSysRstN, padAddrOe, padDataOe, padStrobeOe}, 4'b1000);
    check(padWeN && padOeN && !done && !err, "R1 strobes idle",
          {padWeN, padOeN, done, err}, 4'b1100);
  endtask

  task automatic tRefuse(input bit wr);
    int wf = weFalls, of = oeFalls;
    @(negedge clk);
    wrReq = wr; rdReq = !wr; reqAddr = 17'h00123;
    @(negedge clk);
    wrReq = 0; rdReq = 0;
    check(done && err, "R7 refusal pulse", {done, err}, 2'b11);
    @(negedge clk);
    check(!done && !err, "R7 pulse ends", {done, err}, 2'b00);
    repeat (N + 3) @(negedge clk);
    check(weFalls == wf && oeFalls == of, "R7 no bus activity", weFalls + oeFalls, wf + of);
    check(!padStrobeOe && !padAddrOe && padSysRstN, "R2 still released",
          {padStrobeOe, padAddrOe, padSysRstN}, 3'b001);
  endtask

  task automatic tMode(input bit m);
    @(negedge clk);
    progMode = m;
    repeat (3) @(negedge clk);
    check(padSysRstN == !m && padAddrOe == m && padStrobeOe == m && padDataOe == m,
          m ? "R3 program pads" : "R2 run pads",
          {padSysRstN, padAddrOe, padStrobeOe, padDataOe}, {!m, m, m, m});
  endtask

  task automatic tWriteRead();
    logic [7:0] r;
    logic [16:0] addrs [5] = '{17'h00000, 17'h0FFFF, 17'h10000, 17'h1FFFF, 17'h0A5C3};
    for (int i = 0; i < 5; i++) begin
      expMem[int'(addrs[i])] = 8'h30 + 8'(i * 17);
      doAccess(1, 0, addrs[i], expMem[int'(addrs[i])], r);
    end
    for (int i = 4; i >= 0; i--) begin
      doAccess(0, 1, addrs[i], 8'h00, r);
      check(r == expMem[int'(addrs[i])], "R5 R9 read back", r, expMem[int'(addrs[i])]);
    end
    @(negedge clk);
    check(padDataOe && padDataOut == 8'h00, "R6 zero after read", padDataOut, 0);
  endtask

  task automatic tIgnoreBusy();
    int of = oeFalls, dones = 0;
    @(negedge clk);
    wrReq = 1; reqAddr = 17'h00042; reqData = 8'h5A;
    @(negedge clk);
    wrReq = 0;
    @(negedge clk);
    rdReq = 1;
    @(negedge clk);
    rdReq = 0;
    for (int i = 0; i < N + 8; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    check(dones == 1, "R11 single done", dones, 1);
    check(oeFalls == of, "R11 busy request ignored", oeFalls, of);
  endtask

  task automatic tBoth();
    logic [7:0] r;
    int of = oeFalls;
    doAccess(1, 1, 17'h1234A, 8'hC7, r);
    check(oeFalls == of, "R12 no read", oeFalls, of);
    doAccess(0, 1, 17'h1234A, 8'h00, r);
    check(r == 8'hC7, "R12 write done", r, 8'hC7);
  endtask

  task automatic tDeferred();
    int cyc = 0;
    bit early = 0;
    @(negedge clk);
    wrReq = 1; reqAddr = 17'h00777; reqData = 8'h11;
    @(negedge clk);
    wrReq = 0; progMode = 0;
    while (!done && cyc < 40) begin
      if (padSysRstN) early = 1;
      @(negedge clk);
      cyc++;
    end
    check(!early && !padSysRstN, "R10 host held during access", early, 0);
    @(negedge clk);
    check(padSysRstN && !padAddrOe, "R10 release after done", padSysRstN, 1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tRefuse(1);
    tRefuse(0);
    tMode(1);
    tWriteRead();
    tIgnoreBusy();
    tBoth();
    tDeferred();
    tMode(0);
    tRefuse(0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule